// File: doc/BRIEF.md
# Host-Driven FIFO Handshake Bridge

This block sits between a host slave bus and the byte-wide data FIFO of a storage bus controller that has no DMA engine of its own. The host CPU moves each byte itself by reading or writing a data window, and the bridge turns every window access into one or two request/acknowledge handshakes with the controller. The controller raises its request line (`ctl_dreq`) when it can accept or supply a byte. The bridge answers with `ctl_dack` and moves the byte in the cycle where both lines are high at a clock edge.

When the controller does not raise its request line within a programmable number of cycles, the host access ends with a one-cycle bus error instead of an acknowledge. The host fault handler can then poll the controller and retry the access. A second register holds the 12-bit wait limit and also shows the live state of the request line, so software can see whether the controller is ready again.

The data window is mirrored across its whole span at a 4-byte pitch. Only the lower halfword of each 32-bit slot carries data. An access to the upper halfword still performs the handshakes, and a read there returns all ones.

Top module: `pdma_bridge`

## Requirements
- R1: After synchronous reset, `ctl_dack`, `host_ack` and `host_err` are low, and a read of the configuration register returns 0x000001D1 while `ctl_dreq` is low.
- R2: Every address from 0x100 to 0x1FF is the data window, and addresses that differ only in bits [7:2] behave identically.
- R3: A halfword write to the window (`host_half`=1) makes exactly two handshakes. The first carries `host_wdata[15:8]` and the second carries `host_wdata[7:0]`.
- R4: A halfword read of the lower half of a slot (address bit 1 = 0) returns the first byte in `host_rdata[15:8]` and the second in `host_rdata[7:0]`, with bits [31:16] zero.
- R5: A read whose address bit 1 is 1 still makes the same number of handshakes. It returns 0x0000FFFF for a halfword and 0x000000FF for a byte.
- R6: A byte access (`host_half`=0) makes exactly one handshake. It writes `host_wdata[7:0]`, and on a read returns the byte in `host_rdata[7:0]` with all other bits zero.
- R7: `ctl_dack` drops for at least one cycle between the two bytes of a halfword. A byte moves only at a clock edge where `ctl_dack` and `ctl_dreq` are both high, and `ctl_we` is high for writes.
- R8: If `ctl_dreq` stays low, `ctl_dack` stays high for exactly (limit + 1) cycles. Then `host_err` pulses in the cycle `ctl_dack` falls, no acknowledge is given, and a retried access performs a fresh handshake.
- R9: `host_ack` and `host_err` are never high together and each lasts one cycle. With an immediately ready controller, a halfword completes 4 cycles after the request is taken, a byte 2 cycles after and a register access 1 cycle after.
- R10: The configuration register sits at offset 0x200. A write stores `host_wdata[11:0]` as the wait limit. A read returns the limit in bits [11:0] with bit 9 replaced by `ctl_dreq`, and bits [31:12] zero.
- R11: An access to any other address is acknowledged with read data zero and makes no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until acknowledge or error |
| host_we | input | 1 | 1 = write, 0 = read |
| host_half | input | 1 | 1 = halfword access, 0 = byte access |
| host_addr | input | 12 | Byte offset from the block base |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with `host_ack` |
| host_ack | output | 1 | One-cycle access completion |
| host_err | output | 1 | One-cycle bus error on handshake timeout |
| ctl_dreq | input | 1 | Controller ready for a byte |
| ctl_dack | output | 1 | Bridge handshake strobe to the controller |
| ctl_we | output | 1 | Direction of the current byte, 1 = into the controller |
| ctl_wdata | output | 8 | Byte to the controller |
| ctl_rdata | input | 8 | Byte from the controller |

## Verification
A wrong state in the handshake sequencer shows up at the controller pins within one or two cycles. It appears as a missing gap between the two byte strobes, a byte sent in the wrong order, or a strobe count that does not match the access size. A bad wait counter shows up as a bus error one or more cycles away from the programmed limit plus one, or as an acknowledge where an error was due. A stale response flag is caught in the cycle after a response, when a still-held request would start a second transfer.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} eng_state_t;
  typedef enum logic [1:0] {TGT_NONE, TGT_WIN, TGT_CFG} target_t;
endpackage

// File: rtl/pdma_decode.sv
module pdma_decode
  import pdma_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h100,
  parameter int WIN_LOG2 = 8,
  parameter int CFG_OFS  = 'h200
) (
  input  logic [ADDR_W-1:0] addr,
  output target_t           tgt,
  output logic              upper
);
  localparam logic [ADDR_W-1:0] WB = WIN_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CO = CFG_OFS[ADDR_W-1:0];

  always_comb begin
    if ((addr >> WIN_LOG2) == (WB >> WIN_LOG2)) tgt = TGT_WIN;
    else if (addr == CO)                        tgt = TGT_CFG;
    else                                        tgt = TGT_NONE;
    upper = addr[1];
  end
endmodule

// File: rtl/pdma_cfg.sv
module pdma_cfg #(
  parameter int             CFG_W    = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 12'h1D1,
  parameter int             DREQ_BIT = 9,
  parameter int             DW       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             dreq,
  output logic [CFG_W-1:0] limit,
  output logic [DW-1:0]    status
);
  always_ff @(posedge clk) begin
    if (rst)        limit <= CFG_RST;
    else if (wr_en) limit <= wr_data;
  end

  always_comb begin
    status              = '0;
    status[CFG_W-1:0]   = limit;
    status[DREQ_BIT]    = dreq;
  end
endmodule

// File: rtl/pdma_timeout.sv
module pdma_timeout #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);

  // R8: the wait counter never passes the programmed limit
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (rst) cnt <= limit);
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CFG_W  = 12,
  parameter int DW     = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             host_half,
  input  target_t          tgt,
  input  logic             upper,
  input  logic [DW-1:0]    host_wdata,
  input  logic [DW-1:0]    status,
  output logic             cfg_wr,
  output logic             tmr_clr,
  output logic             tmr_run,
  input  logic             tmr_hit,
  output logic [DW-1:0]    host_rdata,
  output logic             host_ack,
  output logic             host_err,
  input  logic             ctl_dreq,
  output logic             ctl_dack,
  output logic             ctl_we,
  output logic [7:0]       ctl_wdata,
  input  logic [7:0]       ctl_rdata
);
  eng_state_t state;
  logic       two_left;
  logic       is_half;
  logic       is_upper;
  logic [7:0] wlo;
  logic [7:0] rhi;
  logic       accept;

  assign accept  = (state == ST_IDLE) && host_req && !host_ack && !host_err;
  assign cfg_wr  = accept && (tgt == TGT_CFG) && host_we;
  assign tmr_clr = (state != ST_XFER);
  assign tmr_run = (state == ST_XFER) && !ctl_dreq && !tmr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      two_left   <= 1'b0;
      is_half    <= 1'b0;
      is_upper   <= 1'b0;
      wlo        <= '0;
      rhi        <= '0;
      host_rdata <= '0;
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
      ctl_dack   <= 1'b0;
      ctl_we     <= 1'b0;
      ctl_wdata  <= '0;
    end else begin
      host_ack <= 1'b0;
      host_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            unique case (tgt)
              TGT_WIN: begin
                state     <= ST_XFER;
                ctl_dack  <= 1'b1;
                ctl_we    <= host_we;
                ctl_wdata <= host_half ? host_wdata[15:8] : host_wdata[7:0];
                wlo       <= host_wdata[7:0];
                two_left  <= host_half;
                is_half   <= host_half;
                is_upper  <= upper;
              end
              TGT_CFG: begin
                host_ack   <= 1'b1;
                host_rdata <= status;
              end
              default: begin
                host_ack   <= 1'b1;
                host_rdata <= '0;
              end
            endcase
          end
        end
        ST_XFER: begin
          if (ctl_dreq) begin
            ctl_dack <= 1'b0;
            if (two_left) begin
              two_left  <= 1'b0;
              rhi       <= ctl_rdata;
              ctl_wdata <= wlo;
              state     <= ST_GAP;
            end else begin
              state    <= ST_IDLE;
              ctl_we   <= 1'b0;
              host_ack <= 1'b1;
              if (is_upper)     host_rdata <= is_half ? 32'h0000_FFFF : 32'h0000_00FF;
              else if (is_half) host_rdata <= {16'h0, rhi, ctl_rdata};
              else              host_rdata <= {24'h0, ctl_rdata};
            end
          end else if (tmr_hit) begin
            ctl_dack <= 1'b0;
            ctl_we   <= 1'b0;
            host_err <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_GAP: begin
          ctl_dack <= 1'b1;
          state    <= ST_XFER;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_ack_err_excl: assert property (@(posedge clk) disable iff (rst) !(host_ack && host_err));
  a_r9_ack_single: assert property (@(posedge clk) disable iff (rst) host_ack |=> !host_ack);
  a_r9_err_single: assert property (@(posedge clk) disable iff (rst) host_err |=> !host_err);
  a_r8_err_no_dack: assert property (@(posedge clk) disable iff (rst) host_err |-> !ctl_dack);
  a_r7_gap_after_byte: assert property (@(posedge clk) disable iff (rst)
    (ctl_dack && ctl_dreq) |=> !ctl_dack);
endmodule

// File: rtl/pdma_bridge.sv
module pdma_bridge
  import pdma_pkg::*;
#(
  parameter int             ADDR_W   = 12,
  parameter int             DW       = 32,
  parameter int             CFG_W    = 12,
  parameter logic [CFG_W-1:0] CFG_RST = 12'h1D1,
  parameter int             DREQ_BIT = 9,
  parameter int             WIN_BASE = 'h100,
  parameter int             WIN_LOG2 = 8,
  parameter int             CFG_OFS  = 'h200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              host_half,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_ack,
  output logic              host_err,
  input  logic              ctl_dreq,
  output logic              ctl_dack,
  output logic              ctl_we,
  output logic [7:0]        ctl_wdata,
  input  logic [7:0]        ctl_rdata
);
  target_t          tgt;
  logic             upper;
  logic             cfg_wr;
  logic [CFG_W-1:0] limit;
  logic [DW-1:0]    status;
  logic             tmr_clr;
  logic             tmr_run;
  logic             tmr_hit;

  pdma_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2), .CFG_OFS(CFG_OFS)
  ) u_decode (
    .addr(host_addr), .tgt(tgt), .upper(upper)
  );

  pdma_cfg #(
    .CFG_W(CFG_W), .CFG_RST(CFG_RST), .DREQ_BIT(DREQ_BIT), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_data(host_wdata[CFG_W-1:0]),
    .dreq(ctl_dreq), .limit(limit), .status(status)
  );

  pdma_timeout #(.W(CFG_W)) u_timeout (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .limit(limit), .hit(tmr_hit)
  );

  pdma_engine #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .DW(DW)) u_engine (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_half(host_half), .tgt(tgt), .upper(upper), .host_wdata(host_wdata),
    .status(status), .cfg_wr(cfg_wr), .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .tmr_hit(tmr_hit), .host_rdata(host_rdata), .host_ack(host_ack),
    .host_err(host_err), .ctl_dreq(ctl_dreq), .ctl_dack(ctl_dack),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );
endmodule

// File: tb/pdma_bridge_bench.sv
module pdma_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic        host_half = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ack;
  logic        host_err;
  logic        ctl_dreq = 1'b0;
  logic        ctl_dack;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata;

  int tests = 0;
  int fails = 0;

  // controller model
  logic       resp_en = 1'b1;
  logic       force_dreq = 1'b0;
  logic [7:0] rd_seq [4];
  int         rd_idx = 0;
  logic [7:0] wr_log [4];
  int         hs_cnt = 0;
  int         dack_hi = 0;
  int         dack_rise = 0;
  logic       dack_prev = 1'b0;

  // response of the last access
  logic [31:0] r_data;
  logic        r_ack;
  logic        r_err;
  int          r_lat;
  logic        r_dack_at_resp;

  always #10 clk = ~clk;

  pdma_bridge u_pdma_bridge (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_half(host_half), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack(host_ack), .host_err(host_err),
    .ctl_dreq(ctl_dreq), .ctl_dack(ctl_dack), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
  );

  assign ctl_rdata = rd_seq[rd_idx & 3];

  always @(negedge clk) begin
    ctl_dreq <= force_dreq | (resp_en & ctl_dack);
    if (ctl_dack) dack_hi++;
    if (ctl_dack && !dack_prev) dack_rise++;
    dack_prev = ctl_dack;
  end

  always @(posedge clk) begin
    if (!rst && ctl_dack && ctl_dreq) begin
      if (ctl_we) wr_log[hs_cnt & 3] = ctl_wdata;
      hs_cnt++;
      rd_idx <= rd_idx + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    hs_cnt = 0; dack_hi = 0; dack_rise = 0; rd_idx = 0;
  endtask

  task automatic access(input logic we, input logic half, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    clear_mon();
    host_req = 1'b1; host_we = we; host_half = half; host_addr = a; host_wdata = d;
    r_lat = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      r_lat++;
      if (host_ack || host_err) break;
    end
    r_data = host_rdata; r_ack = host_ack; r_err = host_err; r_dack_at_resp = ctl_dack;
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_ack && !host_err, "R9 one-cycle response", {30'h0, host_ack, host_err}, 32'h0);
  endtask

  task automatic t_reset();
    chk(!ctl_dack && !host_ack && !host_err, "R1 reset outputs",
        {29'h0, ctl_dack, host_ack, host_err}, 32'h0);
    access(1'b0, 1'b0, 12'h200, 32'h0);
    chk(r_ack && r_data == 32'h1D1, "R1 cfg reset value", r_data, 32'h1D1);
    chk(r_lat == 1, "R9 register latency", r_lat, 1);
  endtask

  task automatic t_cfg();
    access(1'b1, 1'b0, 12'h200, 32'hFFFF_F5A5);
    access(1'b0, 1'b0, 12'h200, 32'h0);
    chk(r_data == 32'h5A5, "R10 cfg readback dreq low", r_data, 32'h5A5);
    resp_en = 1'b0; force_dreq = 1'b1;
    repeat (2) @(negedge clk);
    access(1'b0, 1'b0, 12'h200, 32'h0);
    chk(r_data == 32'h7A5, "R10 cfg bit9 shows dreq", r_data, 32'h7A5);
    force_dreq = 1'b0; resp_en = 1'b1;
    repeat (2) @(negedge clk);
    access(1'b1, 1'b0, 12'h200, 32'h1D1);
  endtask

  task automatic t_half_write();
    access(1'b1, 1'b1, 12'h100, 32'h1234_BEEF);
    chk(r_ack && hs_cnt == 2, "R3 two handshakes", hs_cnt, 2);
    chk(wr_log[0] == 8'hBE && wr_log[1] == 8'hEF, "R3 high byte first",
        {16'h0, wr_log[0], wr_log[1]}, 32'hBEEF);
    chk(r_lat == 4, "R9 halfword latency", r_lat, 4);
    chk(dack_rise == 2 && dack_hi == 2, "R7 dack gap between bytes", dack_rise, 2);
    access(1'b1, 1'b1, 12'h1F0, 32'h0000_C35A);
    chk(hs_cnt == 2 && wr_log[0] == 8'hC3 && wr_log[1] == 8'h5A, "R2 mirrored write",
        {16'h0, wr_log[0], wr_log[1]}, 32'hC35A);
  endtask

  task automatic t_half_read();
    rd_seq[0] = 8'h9A; rd_seq[1] = 8'h4B;
    access(1'b0, 1'b1, 12'h17C, 32'h0);
    chk(r_ack && r_data == 32'h0000_9A4B, "R4 halfword read order", r_data, 32'h9A4B);
    chk(hs_cnt == 2, "R2 mirrored read handshakes", hs_cnt, 2);
  endtask

  task automatic t_upper();
    access(1'b0, 1'b1, 12'h102, 32'h0);
    chk(r_data == 32'h0000_FFFF && hs_cnt == 2, "R5 upper half read", r_data, 32'hFFFF);
    access(1'b0, 1'b0, 12'h106, 32'h0);
    chk(r_data == 32'h0000_00FF && hs_cnt == 1, "R5 upper byte read", r_data, 32'hFF);
  endtask

  task automatic t_byte();
    access(1'b1, 1'b0, 12'h104, 32'hAAAA_AA77);
    chk(hs_cnt == 1 && wr_log[0] == 8'h77, "R6 byte write", {24'h0, wr_log[0]}, 32'h77);
    chk(r_lat == 2, "R9 byte latency", r_lat, 2);
    rd_seq[0] = 8'hC1;
    access(1'b0, 1'b0, 12'h1A8, 32'h0);
    chk(r_data == 32'h0000_00C1 && hs_cnt == 1, "R6 byte read", r_data, 32'hC1);
  endtask

  task automatic t_timeout();
    access(1'b1, 1'b0, 12'h200, 32'h5);
    resp_en = 1'b0;
    access(1'b0, 1'b1, 12'h100, 32'h0);
    chk(r_err && !r_ack, "R8 bus error on stall", {30'h0, r_ack, r_err}, 32'h1);
    chk(dack_hi == 6, "R8 dack high limit+1 cycles", dack_hi, 6);
    chk(!r_dack_at_resp && hs_cnt == 0, "R8 dack low at error", {31'h0, r_dack_at_resp}, 0);
    resp_en = 1'b1;
    rd_seq[0] = 8'h11; rd_seq[1] = 8'h22;
    access(1'b0, 1'b1, 12'h100, 32'h0);
    chk(r_ack && r_data == 32'h1122 && dack_rise == 2, "R8 clean retry", r_data, 32'h1122);
    access(1'b1, 1'b0, 12'h200, 32'h0);
    resp_en = 1'b0;
    access(1'b1, 1'b0, 12'h104, 32'h0);
    chk(r_err && dack_hi == 1, "R8 zero limit", dack_hi, 1);
    resp_en = 1'b1;
    access(1'b1, 1'b0, 12'h200, 32'h1D1);
  endtask

  task automatic t_unmapped();
    access(1'b0, 1'b1, 12'h040, 32'h0);
    chk(r_ack && r_data == 32'h0 && hs_cnt == 0, "R11 unmapped access", r_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg();
    t_half_write();
    t_half_read();
    t_upper();
    t_byte();
    t_timeout();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule